// File: doc/BRIEF.md
# Arbitration Delay and Millisecond Timebase

This block supplies the time references that a distributed backplane arbiter needs. The host loads the system clock frequency, in whole megahertz, into a divider. The divider turns that clock into one internal tick per microsecond. The same tick drives two consumers. The first is a delay counter that times one of sixteen arbitration settling delays, eight fast and eight slow. The second is a free-running millisecond timer whose pulse marks time inside the arbitration cycle.

The arbiter starts a delay with a one-clock `start` pulse, a 3-bit index and a slow/fast choice. When the delay has elapsed, `dly_done` pulses. For test access, the clamped divider value and the current microsecond count of the millisecond timer can both be read on dedicated outputs.

Top module: `arb_timebase`

## Requirements
- R1: `div_rd` shows the divider value most recently loaded with `div_load`, clamped into 2..40. A load below 2 reads back 2, a load above 40 reads back 40, and after reset it reads 40.
- R2: The internal microsecond tick repeats every `div_rd` clock cycles. A `div_load` restarts its phase, so the first tick is consumed by the edge `div_rd` cycles after the load edge.
- R3: `ms_tick` is high for exactly one clock once every `US_PER_MS` microsecond ticks. Its first pulse follows the edge `US_PER_MS * div_rd` cycles after a load edge, and pulses then repeat at that period.
- R4: `ms_rd` gives the number of microsecond ticks counted in the current millisecond. It is 0 right after a load and right after each `ms_tick`. It does not change between ticks.
- R5: A delay lasts K microsecond ticks. With `slow_mode`=0, K = `dly_sel`+1. With `slow_mode`=1, K = 8*(`dly_sel`+1), where `dly_sel` is an unsigned 3-bit value.
- R6: If `start` and `div_load` share an edge, `dly_done` rises after the edge K*`div_rd` cycles later. It stays high for exactly one clock.
- R7: A `start` during a running delay discards the old count and times the newly selected delay. No `dly_done` follows in the cycle after any `start`.
- R8: During and right after reset, `dly_done`, `ms_tick` and `ms_rd` are 0.
- R9: Once a delay has completed, `dly_done` stays low until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 2 to 40 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| div_load | input | 1 | Load `div_in` into the divider and restart tick phase and ms timer |
| div_in | input | 6 | Clock frequency in MHz |
| dly_sel | input | 3 | Delay index within the chosen bank |
| slow_mode | input | 1 | 1 selects the slow delay bank |
| start | input | 1 | Begin (or restart) a delay |
| dly_done | output | 1 | One-clock pulse when the delay expires |
| ms_tick | output | 1 | One-clock pulse per millisecond |
| div_rd | output | 6 | Clamped divider value readback |
| ms_rd | output | $clog2(US_PER_MS) | Microseconds elapsed in the current millisecond |

## Verification
The bench builds the block with `US_PER_MS` = 25 and the default delay steps of 1 and 8. A millisecond then lasts only 25 microsecond ticks, so several timer wraps and the `ms_rd` readback fit in a few hundred cycles. The full table of delay lengths, with divider settings from the clamped extremes 2 and 40 upward, still fits in a few thousand cycles per vector. The short millisecond also puts the restart of a long slow delay by a short fast one within easy reach.

// File: rtl/arb_timebase_pkg.sv
package arb_timebase_pkg;
  localparam int DIV_W    = 6;
  localparam int SEL_W    = 3;
  localparam int FREQ_MIN = 2;
  localparam int FREQ_MAX = 40;

  // Force a frequency setting into the supported range.
  function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] v);
    if (int'(v) < FREQ_MIN) return DIV_W'(FREQ_MIN);
    if (int'(v) > FREQ_MAX) return DIV_W'(FREQ_MAX);
    return v;
  endfunction

  // Number of microsecond ticks in the selected delay.
  function automatic int unsigned delay_ticks(input logic [SEL_W-1:0] sel,
                                              input logic slow,
                                              input int unsigned fast_step,
                                              input int unsigned slow_step);
    int unsigned step;
    step = slow ? slow_step : fast_step;
    return (int'(sel) + 1) * step;
  endfunction
endpackage

// File: rtl/us_prescaler.sv
module us_prescaler
  import arb_timebase_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  output logic [DIV_W-1:0] div_q,
  output logic             us_tick
);
  logic [DIV_W-1:0] pcnt;
  logic             wrap;

  assign wrap    = (pcnt == div_q - DIV_W'(1));
  assign us_tick = wrap && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= DIV_W'(FREQ_MAX);
      pcnt  <= '0;
    end else if (load) begin
      div_q <= clamp_div(div_in);
      pcnt  <= '0;
    end else if (wrap) begin
      pcnt  <= '0;
    end else begin
      pcnt  <= pcnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/ms_timer.sv
module ms_timer #(
  parameter int US_PER_MS = 1000,
  parameter int MS_W      = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            us_tick,
  output logic [MS_W-1:0] ms_cnt,
  output logic            ms_tick
);
  localparam logic [MS_W-1:0] LAST = MS_W'(US_PER_MS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ms_cnt  <= '0;
      ms_tick <= 1'b0;
    end else begin
      ms_tick <= 1'b0;
      if (clear) begin
        ms_cnt <= '0;
      end else if (us_tick) begin
        if (ms_cnt == LAST) begin
          ms_cnt  <= '0;
          ms_tick <= 1'b1;
        end else begin
          ms_cnt <= ms_cnt + MS_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/delay_unit.sv
module delay_unit
  import arb_timebase_pkg::*;
#(
  parameter int FAST_STEP = 1,
  parameter int SLOW_STEP = 8,
  parameter int CNT_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] sel,
  input  logic             slow,
  input  logic             us_tick,
  output logic             done,
  output logic             busy
);
  logic [CNT_W-1:0] rem;
  logic [CNT_W-1:0] load_val;
  logic             expire;

  assign load_val = CNT_W'(delay_ticks(sel, slow, FAST_STEP, SLOW_STEP));
  assign expire   = busy && us_tick && (rem == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem  <= load_val;
        busy <= 1'b1;
      end else if (expire) begin
        rem  <= '0;
        busy <= 1'b0;
        done <= 1'b1;
      end else if (busy && us_tick) begin
        rem  <= rem - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/arb_timebase.sv
module arb_timebase
  import arb_timebase_pkg::*;
#(
  parameter int US_PER_MS = 1000,
  parameter int FAST_STEP = 1,
  parameter int SLOW_STEP = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         div_load,
  input  logic [5:0]                   div_in,
  input  logic [2:0]                   dly_sel,
  input  logic                         slow_mode,
  input  logic                         start,
  output logic                         dly_done,
  output logic                         ms_tick,
  output logic [5:0]                   div_rd,
  output logic [$clog2(US_PER_MS)-1:0] ms_rd
);
  localparam int MS_W    = $clog2(US_PER_MS);
  localparam int MAX_STP = (FAST_STEP > SLOW_STEP) ? FAST_STEP : SLOW_STEP;
  localparam int CNT_W   = $clog2((2 ** SEL_W) * MAX_STP + 1);

  logic us_tick;
  logic dly_busy;

  us_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (div_load),
    .div_in  (div_in),
    .div_q   (div_rd),
    .us_tick (us_tick)
  );

  ms_timer #(.US_PER_MS(US_PER_MS), .MS_W(MS_W)) u_ms (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (div_load),
    .us_tick (us_tick),
    .ms_cnt  (ms_rd),
    .ms_tick (ms_tick)
  );

  delay_unit #(.FAST_STEP(FAST_STEP), .SLOW_STEP(SLOW_STEP), .CNT_W(CNT_W)) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .sel     (dly_sel),
    .slow    (slow_mode),
    .us_tick (us_tick),
    .done    (dly_done),
    .busy    (dly_busy)
  );
endmodule

// File: rtl/arb_timebase_chk.sv
module arb_timebase_chk #(
  parameter int MS_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            div_load,
  input logic            start,
  input logic            us_tick,
  input logic            dly_busy,
  input logic            dly_done,
  input logic            ms_tick,
  input logic [5:0]      div_rd,
  input logic [MS_W-1:0] ms_rd
);
  p_div_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (div_rd >= 6'd2) && (div_rd <= 6'd40));

  p_ms_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ms_tick |=> !ms_tick);

  p_ms_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ms_tick |-> (ms_rd == '0));

  p_load_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    div_load |=> ((ms_rd == '0) && !ms_tick));

  p_ms_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!us_tick && !div_load) |=> $stable(ms_rd));

  p_done_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dly_done |=> !dly_done);

  p_done_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dly_done |-> $past(us_tick));

  p_start_no_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !dly_done);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dly_busy && !start) |=> !dly_done);
endmodule

bind arb_timebase arb_timebase_chk #(.MS_W(MS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .div_load (div_load),
  .start    (start),
  .us_tick  (us_tick),
  .dly_busy (dly_busy),
  .dly_done (dly_done),
  .ms_tick  (ms_tick),
  .div_rd   (div_rd),
  .ms_rd    (ms_rd)
);

// File: tb/arb_timebase_tb.sv
module arb_timebase_tb;
  localparam int US = 25;
  localparam int MW = $clog2(US);
  localparam int NV = 10;
  // {div_in, slow_mode, dly_sel}
  localparam int VEC [NV][3] = '{
    '{8, 0, 0}, '{3, 0, 7}, '{2, 1, 0}, '{5, 1, 3}, '{0, 0, 2},
    '{63, 0, 1}, '{12, 1, 7}, '{40, 0, 4}, '{7, 1, 5}, '{1, 1, 1}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          div_load = 1'b0;
  logic [5:0]    div_in = '0;
  logic [2:0]    dly_sel = '0;
  logic          slow_mode = 1'b0;
  logic          start = 1'b0;
  logic          dly_done;
  logic          ms_tick;
  logic [5:0]    div_rd;
  logic [MW-1:0] ms_rd;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  arb_timebase #(.US_PER_MS(US)) u_dut (
    .clk(clk), .rst_n(rst_n), .div_load(div_load), .div_in(div_in),
    .dly_sel(dly_sel), .slow_mode(slow_mode), .start(start),
    .dly_done(dly_done), .ms_tick(ms_tick), .div_rd(div_rd), .ms_rd(ms_rd));

  function automatic int exp_div(input int v);
    if (v < 2) return 2;
    if (v > 40) return 40;
    return v;
  endfunction

  function automatic int exp_ticks(input int slow, input int sel);
    return slow != 0 ? 8 * sel + 8 : sel + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  // Count edges until dly_done seen at a negedge; returns count.
  task automatic wait_done(input int limit, output int n);
    n = 0;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (dly_done || n >= limit) break;
    end
  endtask

  initial begin
    int n;
    int d;
    int k;
    // R8: reset state
    repeat (3) @(negedge clk);
    chk(dly_done == 0 && ms_tick == 0, "R8 reset outputs", int'(dly_done) + int'(ms_tick), 0);
    chk(ms_rd == 0, "R8 ms_rd reset", int'(ms_rd), 0);
    chk(div_rd == 40, "R1 div reset", int'(div_rd), 40);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ms_rd == 0 && dly_done == 0, "R8 after reset", int'(ms_rd), 0);

    // R5/R6/R1: vector table, load and start on the same edge
    for (int i = 0; i < NV; i++) begin
      d = exp_div(VEC[i][0]);
      k = exp_ticks(VEC[i][1], VEC[i][2]);
      div_in = 6'(VEC[i][0]);
      slow_mode = VEC[i][1][0];
      dly_sel = 3'(VEC[i][2]);
      div_load = 1'b1;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      div_load = 1'b0;
      start = 1'b0;
      chk(int'(div_rd) == d, "R1 clamp readback", int'(div_rd), d);
      chk(dly_done == 0, "R7 no done after start", int'(dly_done), 0);
      wait_done(k * d + 10, n);
      chk(n == k * d, "R5 R6 delay length", n, k * d);
      @(negedge clk);
      chk(dly_done == 0, "R6 single pulse", int'(dly_done), 0);
    end

    // R2/R3/R4: millisecond timer after a load with divider 4
    div_in = 6'd4;
    div_load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    div_load = 1'b0;
    chk(ms_rd == 0, "R4 cleared by load", int'(ms_rd), 0);
    repeat (11) @(posedge clk);
    @(negedge clk);
    chk(ms_rd == 2, "R2 R4 count before tick", int'(ms_rd), 2);
    @(posedge clk);
    @(negedge clk);
    chk(ms_rd == 3, "R2 R4 count after 12 edges", int'(ms_rd), 3);
    n = 12;
    while (!ms_tick && n < 200) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    chk(n == US * 4, "R3 first ms tick", n, US * 4);
    chk(ms_rd == 0, "R4 wrap on tick", int'(ms_rd), 0);
    @(negedge clk);
    chk(ms_tick == 0, "R3 single pulse", int'(ms_tick), 0);
    n = 1;
    while (!ms_tick && n < 200) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    chk(n == US * 4, "R3 ms period", n, US * 4);

    // R7: restart a long slow delay with a short fast one
    div_in = 6'd3;
    slow_mode = 1'b1;
    dly_sel = 3'd7;
    div_load = 1'b1;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    div_load = 1'b0;
    start = 1'b0;
    k = 0;
    repeat (13) begin
      @(posedge clk);
      @(negedge clk);
      if (dly_done) k++;
    end
    @(posedge clk);
    @(negedge clk);
    slow_mode = 1'b0;
    dly_sel = 3'd1;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(k == 0 && dly_done == 0, "R7 no early done", k, 0);
    wait_done(300, n);
    chk(n == 6, "R7 restarted length", n, 6);

    // R9: quiet after completion
    k = 0;
    repeat (250) begin
      @(posedge clk);
      @(negedge clk);
      if (dly_done) k++;
    end
    chk(k == 0, "R9 idle quiet", k, 0);

    finish_run();
  end
endmodule